// File: doc/BRIEF.md
# Flash Block Protection Policy Unit

This unit keeps the access permissions for every protected block of an on-chip flash array and judges each incoming access against them. An access is one of four kinds: instruction fetch, data read, program or erase. Every block owns two permission bits, a read-enable bit and a program-enable bit. The bits are packed per bank into one read-enable word and one program-enable word, so the unit holds eight permission words with the default of four banks. The verdict (allow or deny) is combinational from the request. A denied program or erase also produces a registered one-cycle violation pulse.

Software can rewrite the permission words, but a write can only clear bits. Protection can therefore be tightened and never relaxed until the next reset. Reset reloads every word from a nonvolatile image input, which discards any change made at run time. A commit sequencer hands the eight words, one at a time in ascending index order, to an external nonvolatile store over a request/acknowledge handshake, so that the current settings can be made permanent.

Top module: `flash_guard`

## Requirements
- R1: While `rst` is high at a clock edge, permission word r (0..7) loads `nv_image[32*r+31 : 32*r]`. Words 0..3 are the read-enable words of banks 0..3 and words 4..7 are the program-enable words of banks 0..3. The same edge clears `viol_pulse`, `cfg_rdata`, `commit_req` and `commit_idx` to 0.
- R2: A request for block number B uses bank (B / 32) mod 4 and bit position B mod 32 of that bank's two words. Block numbers of 128 and above wrap onto the same bits.
- R3: The two bits of a block decode to one of three classes. Read-enable 0 means execute-only, whatever the program-enable bit holds. Read-enable 1 with program-enable 0 means read-only. Both bits at 1 means read/write.
- R4: `req_kind` encodes the access: 0 is fetch, 1 is data read, 2 is program and 3 is erase. Fetch is allowed for every class. A data read is allowed for read-only and read/write blocks. Program and erase are allowed only for read/write blocks. `req_allow` reflects the result in the same cycle as the request.
- R5: A write with `cfg_we` high replaces word `cfg_idx` by its old value AND `cfg_wdata`. A 1 in `cfg_wdata` where the stored bit is 0 has no effect.
- R6: `viol_pulse` is high for exactly the one cycle after a cycle in which `req_valid` was high, `req_kind` was 2 or 3, and the target block was not read/write. A refused data read or a denied kind without `req_valid` does not raise it.
- R7: With `req_valid` low, both `req_allow` and `req_deny` are 0. With `req_valid` high, exactly one of them is 1.
- R8: `commit_go` sampled high while idle starts a commit. From the next cycle, `commit_req` is high with `commit_idx` = 0. `commit_idx` advances by one on each cycle with `commit_ack` high, and the cycle after word 7 is acknowledged `commit_req` falls and `commit_idx` returns to 0. While `commit_req` is high, `commit_data` shows the current value of word `commit_idx`.
- R9: `commit_go` has no effect while a commit is in progress. The index neither restarts nor moves without `commit_ack`.
- R10: `cfg_rdata` shows, one cycle after `cfg_idx` is presented, the value word `cfg_idx` held before any write made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads the permission words |
| nv_image | input | 256 | Reset image of the eight permission words, word r at bits 32r+31..32r |
| req_valid | input | 1 | An access request is present |
| req_kind | input | 2 | Access kind: 0 fetch, 1 data read, 2 program, 3 erase |
| req_block | input | 9 | Target block number |
| req_allow | output | 1 | Request permitted (combinational) |
| req_deny | output | 1 | Request refused (combinational) |
| viol_pulse | output | 1 | One-cycle pulse after a refused program or erase |
| cfg_we | input | 1 | Clear-only write strobe for a permission word |
| cfg_idx | input | 3 | Permission word index for write and read-back |
| cfg_wdata | input | 32 | Write mask; zeros clear bits |
| cfg_rdata | output | 32 | Registered read-back of word `cfg_idx` |
| commit_go | input | 1 | Start saving all words to the nonvolatile store |
| commit_req | output | 1 | Commit transfer pending for word `commit_idx` |
| commit_idx | output | 3 | Index of the word being committed |
| commit_data | output | 32 | Current value of the word being committed |
| commit_ack | input | 1 | Store accepted the current word |

## Verification
On every cycle, the assertions check the following. A fetch is never refused. Allow and deny are exclusive and both low without a request. A violation pulse appears after a refused program or erase, and only then. No permission bit ever rises outside reset. The commit index starts at zero, holds without an acknowledge, steps by one on each acknowledge and releases after the last word. The exact mapping from block number to bank and bit, the three-class decode, the clear-only arithmetic and the live data offered during a commit can only be shown by the bench scenarios, which compare against a behavioural model.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_PROG  = 2'd2,
    ACC_ERASE = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    PERM_EXEC   = 2'd0,
    PERM_RDONLY = 2'd1,
    PERM_RDWR   = 2'd2
  } perm_e;

  // Read-enable dominates: without it the block is execute-only.
  function automatic perm_e decode_perm(input logic rd_en, input logic pg_en);
    perm_e cls;
    if (!rd_en)      cls = PERM_EXEC;
    else if (!pg_en) cls = PERM_RDONLY;
    else             cls = PERM_RDWR;
    return cls;
  endfunction

  function automatic logic kind_ok(input perm_e cls, input acc_kind_e kind);
    logic ok;
    case (kind)
      ACC_FETCH: ok = 1'b1;
      ACC_READ:  ok = (cls != PERM_EXEC);
      default:   ok = (cls == PERM_RDWR);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/fg_perm_regs.sv
module fg_perm_regs #(
  parameter int NB  = 4,
  parameter int BPB = 32
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [2*NB*BPB-1:0]                        nv_image,
  input  logic                                       cfg_we,
  input  logic [$clog2(2*NB)-1:0]                    cfg_idx,
  input  logic [BPB-1:0]                             cfg_wdata,
  output logic [BPB-1:0]                             cfg_rdata,
  input  logic [((NB > 1) ? $clog2(NB) : 1)-1:0]     look_bank,
  input  logic [$clog2(BPB)-1:0]                     look_bit,
  output logic                                       look_re,
  output logic                                       look_pe,
  input  logic [$clog2(2*NB)-1:0]                    cm_idx,
  output logic [BPB-1:0]                             cm_data,
  output logic [2*NB*BPB-1:0]                        perm_flat
);
  localparam int NREG   = 2 * NB;
  localparam int IDX_W  = $clog2(NREG);

  logic [NREG-1:0][BPB-1:0] row_w;

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_row
      logic [BPB-1:0] word_q;
      // Clear-only update: a written 1 can never revive a cleared bit.
      always_ff @(posedge clk) begin
        if (rst)
          word_q <= nv_image[r*BPB +: BPB];
        else if (cfg_we && (cfg_idx == IDX_W'(r)))
          word_q <= word_q & cfg_wdata;
      end
      assign row_w[r]                  = word_q;
      assign perm_flat[r*BPB +: BPB]   = word_q;
    end
  endgenerate

  // Read-back sees the value before any same-cycle write.
  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= row_w[cfg_idx];
  end

  logic [IDX_W-1:0] re_row, pe_row;
  always_comb begin
    re_row  = IDX_W'(look_bank);
    pe_row  = IDX_W'(NB) + IDX_W'(look_bank);
    look_re = row_w[re_row][look_bit];
    look_pe = row_w[pe_row][look_bit];
    cm_data = row_w[cm_idx];
  end

endmodule

// File: rtl/fg_policy.sv
module fg_policy
  import fg_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BPB   = 32,
  parameter int BLK_W = 9
) (
  input  logic                                       req_valid,
  input  logic [1:0]                                 req_kind,
  input  logic [BLK_W-1:0]                           req_block,
  output logic [((NB > 1) ? $clog2(NB) : 1)-1:0]     look_bank,
  output logic [$clog2(BPB)-1:0]                     look_bit,
  input  logic                                       look_re,
  input  logic                                       look_pe,
  output logic                                       allow,
  output logic                                       deny,
  output logic                                       viol_d
);
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int BIT_W  = $clog2(BPB);

  perm_e     cls;
  acc_kind_e kind;
  logic      ok;

  always_comb begin
    // Bank wraps modulo NB for block numbers beyond the protected range.
    look_bank = BANK_W'((req_block / BLK_W'(BPB)) % BLK_W'(NB));
    look_bit  = BIT_W'(req_block % BLK_W'(BPB));
    kind      = acc_kind_e'(req_kind);
    cls       = decode_perm(look_re, look_pe);
    ok        = kind_ok(cls, kind);
    allow     = req_valid & ok;
    deny      = req_valid & ~ok;
    viol_d    = deny & ((kind == ACC_PROG) | (kind == ACC_ERASE));
  end

endmodule

// File: rtl/fg_commit_seq.sv
module fg_commit_seq #(
  parameter int NREG = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic                     ack,
  output logic                     busy,
  output logic [$clog2(NREG)-1:0]  idx
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      if (ack) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end else if (go) begin
      busy <= 1'b1;
      idx  <= '0;
    end
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int NUM_BANKS       = 4,
  parameter int BLOCKS_PER_BANK = 32,
  parameter int BLK_W           = 9
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [2*NUM_BANKS*BLOCKS_PER_BANK-1:0]        nv_image,
  input  logic                                          req_valid,
  input  logic [1:0]                                    req_kind,
  input  logic [BLK_W-1:0]                              req_block,
  output logic                                          req_allow,
  output logic                                          req_deny,
  output logic                                          viol_pulse,
  input  logic                                          cfg_we,
  input  logic [$clog2(2*NUM_BANKS)-1:0]                cfg_idx,
  input  logic [BLOCKS_PER_BANK-1:0]                    cfg_wdata,
  output logic [BLOCKS_PER_BANK-1:0]                    cfg_rdata,
  input  logic                                          commit_go,
  output logic                                          commit_req,
  output logic [$clog2(2*NUM_BANKS)-1:0]                commit_idx,
  output logic [BLOCKS_PER_BANK-1:0]                    commit_data,
  input  logic                                          commit_ack
);
  localparam int NREG   = 2 * NUM_BANKS;
  localparam int IMG_W  = NREG * BLOCKS_PER_BANK;
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int BIT_W  = $clog2(BLOCKS_PER_BANK);

  logic [BANK_W-1:0] look_bank;
  logic [BIT_W-1:0]  look_bit;
  logic              look_re, look_pe;
  logic              viol_d;
  logic [IMG_W-1:0]  perm_flat;

  fg_perm_regs #(.NB(NUM_BANKS), .BPB(BLOCKS_PER_BANK)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .nv_image  (nv_image),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .look_bank (look_bank),
    .look_bit  (look_bit),
    .look_re   (look_re),
    .look_pe   (look_pe),
    .cm_idx    (commit_idx),
    .cm_data   (commit_data),
    .perm_flat (perm_flat)
  );

  fg_policy #(.NB(NUM_BANKS), .BPB(BLOCKS_PER_BANK), .BLK_W(BLK_W)) u_policy (
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_block (req_block),
    .look_bank (look_bank),
    .look_bit  (look_bit),
    .look_re   (look_re),
    .look_pe   (look_pe),
    .allow     (req_allow),
    .deny      (req_deny),
    .viol_d    (viol_d)
  );

  fg_commit_seq #(.NREG(NREG)) u_commit (
    .clk  (clk),
    .rst  (rst),
    .go   (commit_go),
    .ack  (commit_ack),
    .busy (commit_req),
    .idx  (commit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) viol_pulse <= 1'b0;
    else     viol_pulse <= viol_d;
  end

endmodule

// File: rtl/fg_sva.sv
module fg_sva #(
  parameter int NREG  = 8,
  parameter int BPB   = 32,
  parameter int IDX_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic [1:0]            req_kind,
  input logic                  req_allow,
  input logic                  req_deny,
  input logic                  viol_pulse,
  input logic                  commit_ack,
  input logic                  commit_req,
  input logic [IDX_W-1:0]      commit_idx,
  input logic [NREG*BPB-1:0]   perm_flat
);
  logic seen_rst = 1'b0;
  logic settled  = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    settled <= seen_rst & ~rst;
  end

  // R4
  fetch_always_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    (req_valid && req_kind == 2'd0) |-> req_allow);

  // R7
  allow_deny_excl_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    (req_valid |-> (req_allow != req_deny)) and (!req_valid |-> (!req_allow && !req_deny)));

  // R6
  viol_follows_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    (req_deny && req_kind[1]) |=> viol_pulse);

  // R6
  viol_cause_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    viol_pulse |-> $past(req_deny && req_kind[1]));

  // R5
  no_bit_rise_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    !$past(rst) |-> ((perm_flat & ~$past(perm_flat)) == '0));

  // R8
  idx_step_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    (commit_req && commit_ack && commit_idx != IDX_W'(NREG - 1))
      |=> (commit_req && commit_idx == $past(commit_idx) + 1'b1));

  // R8
  last_release_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    (commit_req && commit_ack && commit_idx == IDX_W'(NREG - 1)) |=> !commit_req);

  // R8
  start_at_zero_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    $rose(commit_req) |-> commit_idx == '0);

  // R9
  hold_without_ack_chk: assert property (@(posedge clk) disable iff (rst || !settled)
    (commit_req && !commit_ack) |=> (commit_req && $stable(commit_idx)));

endmodule

bind flash_guard fg_sva #(.NREG(NREG), .BPB(BLOCKS_PER_BANK), .IDX_W($clog2(2*NUM_BANKS))) u_sva (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_allow  (req_allow),
  .req_deny   (req_deny),
  .viol_pulse (viol_pulse),
  .commit_ack (commit_ack),
  .commit_req (commit_req),
  .commit_idx (commit_idx),
  .perm_flat  (perm_flat)
);

// File: tb/tb_flash_guard.sv
`timescale 1ns/1ps
module tb_flash_guard;
  localparam int NB = 4, BPB = 32, BLK_W = 9, NREG = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst, req_valid, cfg_we, commit_go, commit_ack;
  logic [NREG*BPB-1:0]  nv_image;
  logic [1:0]           req_kind;
  logic [BLK_W-1:0]     req_block;
  logic [2:0]           cfg_idx;
  logic [31:0]          cfg_wdata;
  logic                 req_allow, req_deny, viol_pulse, commit_req;
  logic [31:0]          cfg_rdata, commit_data;
  logic [2:0]           commit_idx;

  flash_guard dut (.*);

  // Behavioural reference state
  bit [31:0] m_row [NREG];
  bit [31:0] m_rdata;
  bit        m_viol, m_busy, m_live, done;
  int        m_idx;
  int        vecs = 0, errs = 0;
  string     phase = "R1";

  function automatic bit permit(input int kind, input int blk);
    int bank = (blk / BPB) % NB;
    int bpos = blk % BPB;
    bit re = m_row[bank][bpos];
    bit pe = m_row[NB + bank][bpos];
    if (kind == 0) return 1'b1;
    if (kind == 1) return re;
    return re & pe;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s (phase %s) act=%h exp=%h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit p;
    p = permit(int'(req_kind), int'(req_block));
    chk("R4 allow", 32'(req_allow), 32'(req_valid & p));
    chk("R7 deny", 32'(req_deny), 32'(req_valid & ~p));
    chk("R6 viol", 32'(viol_pulse), 32'(m_viol));
    chk("R10 rdata", cfg_rdata, m_rdata);
    chk("R8 req", 32'(commit_req), 32'(m_busy));
    chk("R8 idx", 32'(commit_idx), 32'(m_idx));
    if (m_busy) chk("R8 data", commit_data, m_row[m_idx]);
  endtask

  task automatic tick();
    bit [31:0] n_rdata;
    bit        n_viol;
    #1;
    if (m_live) compare();
    if (rst) begin
      for (int r = 0; r < NREG; r++) m_row[r] = nv_image[r*BPB +: BPB];
      n_rdata = 0; n_viol = 0; m_busy = 0; m_idx = 0;
    end else begin
      n_rdata = m_row[cfg_idx];
      n_viol  = req_valid && req_kind[1] && !permit(int'(req_kind), int'(req_block));
      if (m_busy) begin
        if (commit_ack) begin
          if (m_idx == NREG - 1) begin m_busy = 0; m_idx = 0; end
          else m_idx++;
        end
      end else if (commit_go) begin
        m_busy = 1; m_idx = 0;
      end
      if (cfg_we) m_row[cfg_idx] = m_row[cfg_idx] & cfg_wdata;
    end
    @(posedge clk);
    m_rdata = n_rdata; m_viol = n_viol;
    if (rst) m_live = 1;
    @(negedge clk);
  endtask

  task automatic req(input int kind, input int blk);
    req_valid = 1; req_kind = 2'(kind); req_block = BLK_W'(blk); tick();
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = d; tick(); cfg_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    bit [31:0] lf = 32'h1234_5678;
    rst = 1; req_valid = 0; req_kind = 0; req_block = 0; cfg_we = 0; cfg_idx = 0;
    cfg_wdata = 0; commit_go = 0; commit_ack = 0; nv_image = '1;
    @(negedge clk);
    tick(); tick(); rst = 0;
    // R1: all-ones image read back
    for (int i = 0; i < NREG; i++) begin cfg_idx = 3'(i); tick(); end
    tick();
    chk("R1 image", cfg_rdata, 32'hFFFF_FFFF);

    phase = "R4";
    for (int k = 0; k < 4; k++) begin req(k, 0); req(k, 100); req(k, 511); end
    req_valid = 0;

    phase = "R5";
    wr(0, ~(32'h1 << 3));
    wr(4, ~(32'h1 << 7));
    wr(0, 32'hFFFF_FFFF);
    cfg_idx = 0; tick(); tick();
    chk("R5 clear-only", cfg_rdata, ~(32'h1 << 3));
    cfg_idx = 4; tick(); tick();
    chk("R5 pe word", cfg_rdata, ~(32'h1 << 7));

    phase = "R3";
    for (int k = 0; k < 4; k++) begin req(k, 3); req(k, 7); req(k, 8); end
    req(1, 3); req_valid = 0;
    chk("R3 read of exec-only not a violation", 32'(viol_pulse), 32'h0);
    req_valid = 0; req_kind = 2; req_block = 7; tick();
    chk("R7 no request", 32'(req_allow | req_deny), 32'h0);
    tick();

    phase = "R2";
    wr(5, ~(32'h1 << 5));
    req(2, 37); req(3, 165); req(2, 5); req(2, 36);
    wr(3, ~(32'h1 << 31));
    req(1, 127); req(1, 255); req(1, 511); req(0, 511); req(1, 126);
    req_valid = 0; tick();

    phase = "R8";
    commit_go = 1; tick(); commit_go = 0;
    for (int c = 0; c < 30; c++) begin
      commit_ack = (c % 3 == 2);
      if (c == 4) begin cfg_we = 1; cfg_idx = 1; cfg_wdata = 32'hFFFF_FFFE; end
      else cfg_we = 0;
      if (c == 7) phase = "R9";
      commit_go = (c == 7 || c == 8);
      tick();
    end
    commit_ack = 0; commit_go = 0; cfg_we = 0;
    chk("R8 idle after last", 32'(commit_req), 32'h0);
    tick();

    phase = "R1 reload";
    rst = 1;
    for (int r = 0; r < NREG; r++) nv_image[r*BPB +: BPB] = 32'hA5C3_F00F ^ (32'h1111_1111 * r);
    tick(); tick(); rst = 0;
    for (int i = 0; i < NREG; i++) begin cfg_idx = 3'(i); tick(); end
    tick();

    phase = "R8 mix";
    for (int c = 0; c < 4000; c++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      req_valid  = lf[0];
      req_kind   = lf[2:1];
      req_block  = lf[11:3];
      cfg_we     = (lf[15:12] == 4'h0);
      cfg_idx    = lf[18:16];
      cfg_wdata  = ~(32'h1 << lf[23:19]);
      commit_go  = (lf[28:24] == 5'h3);
      commit_ack = lf[29];
      if (c == 2000) begin rst = 1; nv_image = '1; end
      else rst = 0;
      tick();
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule